// File: doc/BRIEF.md
# Multi-Mode Digest Length Formatter

This block turns four 32-bit partial digest words into a finished hash code of a chosen length. A two-bit mode picks one of four recipes: a 64-bit code formed from a wrapped sum and a wrapped product, an 18-bit code cut from that 64-bit value by trimming and decimation, a 128-bit code formed by rotating each word left by its own amount, and a 128-bit code built from two wrapped sums and two wrapped products. All sums and products keep only their low 32 bits.

A request is a one-cycle `start_i` pulse with the mode and words present. The block captures them, computes both products with a shared-timing shift-and-add multiplier, and then raises `done_o` for exactly one cycle. The result and a length code are registered and stay on the outputs until the next `done_o` pulse. While a request is in flight, further start pulses are dropped. The cycle in which `done_o` is high already counts as idle, so a new request can be issued in that cycle.

Top module: `digest_len_fmt`

## Requirements
- R1: After reset, `done_o` is 0, `digest_o` is all zeros and `len_code_o` is 0.
- R2: Mode 2'b00 gives `digest_o[63:32]` = (W1+W3 mod 2^32) rotated left 5 and `digest_o[31:0]` = (W2*W4 mod 2^32) rotated left 10. `digest_o[127:64]` is 0. Sums wrap, and products keep their low 32 bits.
- R3: Mode 2'b01 takes the 64-bit value h that mode 2'b00 would produce and places an 18-bit result in `digest_o[17:0]`, with `digest_o[127:18]` = 0. Result bit 17-k equals h[57-3k] for k = 0..17. For h = f41d3352753f20dc the result is 001110011101110001.
- R4: Mode 2'b10 gives, from bit 127 down, W1 rotated left 7, W2 rotated left 10, W3 rotated left 15 and W4 rotated left 5.
- R5: Mode 2'b11 gives, from bit 127 down, (W1+W3)<<<5, (W2*W4)<<<10, (W2+W4)<<<5 and (W1*W3)<<<10, all modulo 2^32.
- R6: With `done_o`, `len_code_o` reads 2'd0 for the 64-bit mode, 2'd1 for the 18-bit mode and 2'd2 for both 128-bit modes.
- R7: Each accepted start yields exactly one `done_o` pulse, one cycle wide. `digest_o` and `len_code_o` change only in the cycle in which `done_o` rises.
- R8: A start pulse that arrives while a request is in flight is ignored. It produces no extra `done_o` and does not alter the pending result.
- R9: A start pulse in the same cycle as `done_o` is accepted and produces its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request pulse; inputs are captured when the block is idle |
| mode_i | input | 2 | Recipe select: 00 = 64-bit, 01 = 18-bit, 10 = rotate 128-bit, 11 = add/multiply 128-bit |
| word1_i | input | 32 | Partial digest word W1 |
| word2_i | input | 32 | Partial digest word W2 |
| word3_i | input | 32 | Partial digest word W3 |
| word4_i | input | 32 | Partial digest word W4 |
| done_o | output | 1 | One-cycle result pulse |
| digest_o | output | 128 | Result, with narrow codes right-aligned and zero-filled |
| len_code_o | output | 2 | Length code of the result |

## Verification
Two events can fall in the same cycle: the completion pulse of one request and the acceptance of the next. Both can also meet a stray start during the final multiply step, which must be dropped. The bench waits for `done_o` and drives a new start in that same cycle. It also injects a start with different words partway through a busy period. The scoreboard judges the outcome: every queued expectation must be matched by exactly one pulse carrying the right value, and a pulse that arrives with no pending expectation is a failure.

// File: rtl/dlf_pkg.sv
// Shared types and helpers for the digest length formatter.
// Assumes a 32-bit word; every other width is derived from it.
package dlf_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned OUT_W  = 4 * WORD_W;

    typedef enum logic [1:0] {
        MODE_W64   = 2'b00,
        MODE_W18   = 2'b01,
        MODE_ROT   = 2'b10,
        MODE_ADDMUL = 2'b11
    } mode_e;

    localparam logic [1:0] LEN_64  = 2'd0;
    localparam logic [1:0] LEN_18  = 2'd1;
    localparam logic [1:0] LEN_128 = 2'd2;

    // Circular left rotation of one word by a fixed amount.
    function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x,
                                               input int unsigned s);
        return (x << s) | (x >> (WORD_W - s));
    endfunction
endpackage

// File: rtl/dlf_seq_mul.sv
// Sequential shift-and-add multiplier, one multiplier bit per cycle.
// Assumes go is sampled only while the unit is idle; the product keeps the
// low W bits and is valid in the cycle ready_o is high.
module dlf_seq_mul #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] prod_o,
    output logic         ready_o
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  mcand_q, mplier_q, acc_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q, ready_q;

    // Load operands on go, then add and shift once per cycle for W cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
            cnt_q    <= '0;
            busy_q   <= 1'b0;
            ready_q  <= 1'b0;
        end else begin
            ready_q <= 1'b0;
            if (go_i && !busy_q) begin
                mcand_q  <= a_i;
                mplier_q <= b_i;
                acc_q    <= '0;
                cnt_q    <= CW'(W);
                busy_q   <= 1'b1;
            end else if (busy_q) begin
                if (mplier_q[0]) acc_q <= acc_q + mcand_q;
                mcand_q  <= mcand_q << 1;
                mplier_q <= mplier_q >> 1;
                cnt_q    <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    busy_q  <= 1'b0;
                    ready_q <= 1'b1;
                end
            end
        end
    end

    assign prod_o  = acc_q;
    assign ready_o = ready_q;

    AST_MUL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |=> !ready_q); // R7
    AST_MUL_IDLE_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |-> !busy_q); // R7
endmodule

// File: rtl/dlf_decimate.sv
// Trims TRIM bits from each end of the input, then keeps the first bit of
// every STEP-bit group counted from the most significant end.
// Purely combinational; assumes IN_W > 2*TRIM.
module dlf_decimate #(
    parameter int unsigned IN_W = 64,
    parameter int unsigned TRIM = 6,
    parameter int unsigned STEP = 3,
    localparam int unsigned KEEP_W = IN_W - 2 * TRIM,
    localparam int unsigned DEC_W  = (KEEP_W + STEP - 1) / STEP
) (
    input  logic [IN_W-1:0]  din_i,
    output logic [DEC_W-1:0] dout_o
);
    // One wire per kept bit, MSB of the result from the top of the window.
    for (genvar k = 0; k < DEC_W; k++) begin : g_pick
        assign dout_o[DEC_W-1-k] = din_i[IN_W-1-TRIM-STEP*k];
    end
endmodule

// File: rtl/dlf_assemble.sv
// Builds the registered-side result word and length code from the captured
// words and the two finished products. Combinational; assumes the products
// correspond to the captured words when the caller samples the result.
module dlf_assemble
    import dlf_pkg::*;
#(
    parameter int unsigned ROT_SUM  = 5,
    parameter int unsigned ROT_PROD = 10,
    parameter int unsigned ROT_W1   = 7,
    parameter int unsigned ROT_W2   = 10,
    parameter int unsigned ROT_W3   = 15,
    parameter int unsigned ROT_W4   = 5,
    parameter int unsigned TRIM     = 6,
    parameter int unsigned STEP     = 3
) (
    input  mode_e             mode_i,
    input  logic [WORD_W-1:0] w1_i,
    input  logic [WORD_W-1:0] w2_i,
    input  logic [WORD_W-1:0] w3_i,
    input  logic [WORD_W-1:0] w4_i,
    input  logic [WORD_W-1:0] prod24_i,
    input  logic [WORD_W-1:0] prod13_i,
    output logic [OUT_W-1:0]  digest_o,
    output logic [1:0]        len_o
);
    localparam int unsigned H_W   = 2 * WORD_W;
    localparam int unsigned DEC_W = (H_W - 2 * TRIM + STEP - 1) / STEP;

    logic [WORD_W-1:0] sum13, sum24;
    logic [H_W-1:0]    h64;
    logic [DEC_W-1:0]  h_dec;

    assign sum13 = w1_i + w3_i;
    assign sum24 = w2_i + w4_i;
    assign h64   = {rotl(sum13, ROT_SUM), rotl(prod24_i, ROT_PROD)};

    dlf_decimate #(.IN_W(H_W), .TRIM(TRIM), .STEP(STEP)) u_dec (
        .din_i  (h64),
        .dout_o (h_dec)
    );

    // Select the recipe and its length code.
    always_comb begin
        digest_o = '0;
        len_o    = LEN_128;
        unique case (mode_i)
            MODE_W64: begin
                digest_o = {{(OUT_W-H_W){1'b0}}, h64};
                len_o    = LEN_64;
            end
            MODE_W18: begin
                digest_o = {{(OUT_W-DEC_W){1'b0}}, h_dec};
                len_o    = LEN_18;
            end
            MODE_ROT: begin
                digest_o = {rotl(w1_i, ROT_W1), rotl(w2_i, ROT_W2),
                            rotl(w3_i, ROT_W3), rotl(w4_i, ROT_W4)};
            end
            default: begin
                digest_o = {h64, rotl(sum24, ROT_SUM), rotl(prod13_i, ROT_PROD)};
            end
        endcase
    end

    always_comb begin
        AST_NARROW_FITS: assert (len_o != LEN_18 || digest_o[OUT_W-1:DEC_W] == '0); // R3
    end
endmodule

// File: rtl/digest_len_fmt.sv
// Top level: accepts a request when idle, runs two multipliers in lock-step,
// registers the assembled result and pulses done for one cycle.
// Assumes a synchronous active-low reset; start is ignored while busy.
module digest_len_fmt
    import dlf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    mode_i,
    input  logic [31:0]   word1_i,
    input  logic [31:0]   word2_i,
    input  logic [31:0]   word3_i,
    input  logic [31:0]   word4_i,
    output logic          done_o,
    output logic [127:0]  digest_o,
    output logic [1:0]    len_code_o
);
    localparam int unsigned LANES = 2;

    typedef enum logic { ST_IDLE = 1'b0, ST_BUSY = 1'b1 } state_e;

    state_e            state_q;
    mode_e             mode_q;
    logic [WORD_W-1:0] op_q [4];
    logic [OUT_W-1:0]  digest_q, digest_d;
    logic [1:0]        len_q, len_d;
    logic              done_q;
    logic              accept;

    logic [WORD_W-1:0] mul_a [LANES];
    logic [WORD_W-1:0] mul_b [LANES];
    logic [WORD_W-1:0] mul_p [LANES];
    logic [LANES-1:0]  mul_rdy;

    assign accept = start_i && (state_q == ST_IDLE);

    // Lane 0 forms W2*W4, lane 1 forms W1*W3, operands straight from the pins.
    assign mul_a[0] = word2_i;
    assign mul_b[0] = word4_i;
    assign mul_a[1] = word1_i;
    assign mul_b[1] = word3_i;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        dlf_seq_mul #(.W(WORD_W)) u_mul (
            .clk     (clk),
            .rst_n   (rst_n),
            .go_i    (accept),
            .a_i     (mul_a[l]),
            .b_i     (mul_b[l]),
            .prod_o  (mul_p[l]),
            .ready_o (mul_rdy[l])
        );
    end

    dlf_assemble u_asm (
        .mode_i   (mode_q),
        .w1_i     (op_q[0]),
        .w2_i     (op_q[1]),
        .w3_i     (op_q[2]),
        .w4_i     (op_q[3]),
        .prod24_i (mul_p[0]),
        .prod13_i (mul_p[1]),
        .digest_o (digest_d),
        .len_o    (len_d)
    );

    // Capture the request, track busy, and register the finished result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= MODE_W64;
            op_q     <= '{default: '0};
            digest_q <= '0;
            len_q    <= LEN_64;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state_q <= ST_BUSY;
                mode_q  <= mode_e'(mode_i);
                op_q[0] <= word1_i;
                op_q[1] <= word2_i;
                op_q[2] <= word3_i;
                op_q[3] <= word4_i;
            end else if (state_q == ST_BUSY && mul_rdy[0]) begin
                state_q  <= ST_IDLE;
                digest_q <= digest_d;
                len_q    <= len_d;
                done_q   <= 1'b1;
            end
        end
    end

    assign done_o     = done_q;
    assign digest_o   = digest_q;
    assign len_code_o = len_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> ($stable(digest_q) && $stable(len_q))); // R7
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && start_i) |=> ($stable(op_q[0]) && $stable(op_q[3]) && $stable(mode_q))); // R8
    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && start_i) |=> (state_q == ST_BUSY)); // R9
    AST_W64_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && len_q == LEN_64) |-> (digest_q[127:64] == '0)); // R2
    AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        mul_rdy[0] |-> (state_q == ST_BUSY)); // R7
endmodule

// File: tb/tb_digest_len_fmt.sv
`timescale 1ns/1ps
module tb_digest_len_fmt;
    localparam int unsigned MUL_CYC = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   mode_i = 2'b00;
    logic [31:0]  word1_i = '0, word2_i = '0, word3_i = '0, word4_i = '0;
    logic         done_o;
    logic [127:0] digest_o;
    logic [1:0]   len_code_o;

    always #4 clk = ~clk;

    digest_len_fmt dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .word1_i(word1_i), .word2_i(word2_i), .word3_i(word3_i), .word4_i(word4_i),
        .done_o(done_o), .digest_o(digest_o), .len_code_o(len_code_o)
    );

    typedef struct {
        logic [127:0] dig;
        logic [1:0]   len;
        logic [1:0]   mode;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;

    function automatic logic [31:0] rl(input logic [31:0] x, input int s);
        return (x << s) | (x >> (32 - s));
    endfunction

    function automatic string req_of(input logic [1:0] m);
        case (m)
            2'b00: return "R2";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [1:0] m, input logic [31:0] a,
                                   input logic [31:0] b, input logic [31:0] c,
                                   input logic [31:0] d);
        exp_t e;
        logic [31:0] s13, s24, p24, p13;
        logic [63:0] h;
        logic [17:0] dec;
        s13 = a + c;
        s24 = b + d;
        p24 = b * d;
        p13 = a * c;
        h = {rl(s13, 5), rl(p24, 10)};
        for (int k = 0; k < 18; k++) dec[17-k] = h[57-3*k];
        e.mode = m;
        case (m)
            2'b00: begin e.dig = {64'd0, h};  e.len = 2'd0; end
            2'b01: begin e.dig = {110'd0, dec}; e.len = 2'd1; end
            2'b10: begin e.dig = {rl(a,7), rl(b,10), rl(c,15), rl(d,5)}; e.len = 2'd2; end
            default: begin e.dig = {h, rl(s24,5), rl(p13,10)}; e.len = 2'd2; end
        endcase
        return e;
    endfunction

    task automatic check128(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request at the current negedge and queue its expectation.
    task automatic issue(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input logic [31:0] d);
        mode_i = m; word1_i = a; word2_i = b; word3_i = c; word4_i = d;
        start_i = 1'b1;
        exp_q.push_back(model(m, a, b, c, d));
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Return at the negedge where done is seen.
    task automatic wait_done;
        do @(negedge clk); while (done_o !== 1'b1);
    endtask

    // Scoreboard monitor: pops one expectation per done pulse.
    always @(negedge clk) begin
        if (rst_n && done_o === 1'b1) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R8: actual unexpected done expected none");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check128(req_of(e.mode), digest_o, e.dig);
                check128("R6", {126'd0, len_code_o}, {126'd0, e.len});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check128("R1", {125'd0, done_o, len_code_o}, 128'd0);
        check128("R1", digest_o, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: known 64-bit value from W1+W3 = 97a0e99a and W2*W4 = 371d4fc8
        issue(2'b00, 32'h97a0e99a, 32'h371d4fc8, 32'h0, 32'h1);
        wait_done();
        check128("R2", digest_o, {64'd0, 64'hf41d3352753f20dc});
        @(negedge clk);

        // R3: decimation of f41d3352753f20dc
        issue(2'b01, 32'h97a0e99a, 32'h371d4fc8, 32'h0, 32'h1);
        wait_done();
        check128("R3", digest_o, {110'd0, 18'b001110011101110001});
        @(negedge clk);

        // R5: first two words match the known pair
        issue(2'b11, 32'h97a0e99a, 32'h371d4fc8, 32'h0, 32'h1);
        wait_done();
        check128("R5", {64'd0, digest_o[127:64]}, {64'd0, 64'hf41d3352753f20dc});
        @(negedge clk);

        // R4: rotation pattern with edge bits set
        issue(2'b10, 32'h80000001, 32'hc0000003, 32'h00018000, 32'hf0000000);
        wait_done();
        @(negedge clk);

        // R2: wrap-around of sum and product
        issue(2'b00, 32'hffffffff, 32'hffffffff, 32'h00000001, 32'hffffffff);
        wait_done();
        check128("R2", digest_o, {64'd0, 32'h0, 32'h00000400});
        @(negedge clk);

        // R2 R3 R4 R5: pseudo-random words in every mode
        for (int i = 0; i < 8; i++) begin
            issue(2'(i), $urandom, $urandom, $urandom, $urandom);
            wait_done();
            @(negedge clk);
        end

        // R8: stray start while busy is dropped
        issue(2'b10, 32'h12345678, 32'h9abcdef0, 32'h0f1e2d3c, 32'h4b5a6978);
        repeat (5) @(negedge clk);
        mode_i = 2'b00; word1_i = 32'hdeadbeef; word2_i = 32'h1; word3_i = 32'h2; word4_i = 32'h3;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        repeat (2 * MUL_CYC + 4) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R8: actual %0d pending expected 0", exp_q.size());
        end

        // R9: new start in the done cycle, then once more back to back
        issue(2'b11, 32'h00010001, 32'hfffffffe, 32'h7fffffff, 32'h00000003);
        wait_done();
        issue(2'b01, 32'hcafef00d, 32'h0badc0de, 32'h13579bdf, 32'h2468ace0);
        wait_done();
        issue(2'b00, 32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444);
        wait_done();
        repeat (2 * MUL_CYC + 4) @(negedge clk);
        // R7 R9: every accepted start produced exactly one result
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9: actual %0d pending expected 0", exp_q.size());
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule